// File: doc/BRIEF.md
# Expansion Interface I/O Port Decoder

This block is the processor-facing I/O logic of an expansion interface that serves a tape-loop storage drive, an RS-232 link and a single-wire network. Address bits 4 and 3 split the I/O space into three claimed ports: a drive data port, a control/status port and a shared serial/network bit port. The fourth address combination is not claimed. The block forwards those accesses by raising a pass-through enable for the next device on the bus.

A write to the control port updates a stored control byte. The drive, serial and network sides see its active-low bits as decoded active-high levels. Short strobes mark when the drive control group or the serial CTS line has actually changed. A read of the control port returns a status byte built from drive, serial and network conditions. A single stored control bit decides whether a serial/network write feeds the serial receive line or the network output. A drive data read holds the processor in wait until the drive side delivers a byte, with no timeout.

Top module: `exp_io_decoder`

## Requirements
- R1: An access whose address has bit 4 = 1 and bit 3 = 1 is unclaimed. While its strobe is present, pass_en is 1. It produces no cpu_rvalid, cpu_rdata stays 0 and no output strobe fires.
- R2: After reset the control byte is 0xEE. This gives drv_dout=1, drv_erase=0, drv_write=0, drv_clk=0 and ser_cts=1. The DTR sample resets to asserted. A first serial/network read with ser_txd=1 returns 0x7E.
- R3: A read with bit 4 = 0 and bit 3 = 1 returns a status byte one cycle after the strobe, with cpu_rvalid high. The byte holds bits 7..5 at 1, bit 4 = not net_busy, bit 3 = not DTR, bit 2 = not drv_gap, bit 1 = not drv_sync and bit 0 = not drv_wprot. With all drive conditions 0 and DTR and busy asserted it reads 0xE7.
- R4: DTR is sampled from ser_dtr on every clock. The drive and busy inputs are taken at the read edge.
- R5: A write with bit 4 = 0 and bit 3 = 1 stores the byte. The outputs drv_dout, drv_clk, drv_write, drv_erase and ser_cts are the inverses of stored bits 0, 1, 2, 3 and 4.
- R6: drv_ctrl_stb pulses for one cycle after a control write only when stored bits 3..0 change.
- R7: ser_cts_stb pulses for one cycle after a control write only when stored bit 4 changes.
- R8: net_wait_req pulses for one cycle after every control write whose bit 5 is 0, even if that bit was already 0.
- R9: A write with bit 4 = 1 and bit 3 = 0 routes data bit 0 by stored control bit 0. When that bit is 1, ser_rxd takes the inverse of data bit 0 and ser_rx_stb pulses. When it is 0, net_out takes data bit 0 and net_out_stb pulses.
- R10: A serial/network read returns bit 7 = not ser_txd, bits 6..1 = 1, and bit 0 = not net_in. Bit 0 is refreshed only when stored control bit 4 is 1; otherwise it keeps the last latched value.
- R11: A read with bits 4 and 3 both 0 and drv_byte_rdy low raises cpu_wait and holds it for as long as drv_byte_rdy stays low. In the cycle after drv_byte_rdy is seen, cpu_wait falls and cpu_rvalid, drv_rd_ack and cpu_rdata = drv_rx_byte appear together. If drv_byte_rdy is already high at the strobe, the read completes in one cycle without wait.
- R12: A write with bits 4 and 3 both 0 presents the byte on drv_tx_byte with a one-cycle drv_tx_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | I/O address |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid, else 0 |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_wait | output | 1 | Processor stall during a data read |
| pass_en | output | 1 | Unclaimed access goes to the next device |
| drv_wprot | input | 1 | Cartridge write-protected |
| drv_sync | input | 1 | Sync pattern present |
| drv_gap | input | 1 | Gap present |
| drv_byte_rdy | input | 1 | A full byte has been collected |
| drv_rx_byte | input | 8 | Collected byte |
| drv_rd_ack | output | 1 | Byte taken by the processor |
| drv_tx_byte | output | 8 | Byte to record |
| drv_tx_stb | output | 1 | drv_tx_byte valid |
| drv_ctrl_stb | output | 1 | Drive control group changed |
| drv_erase | output | 1 | Erase level |
| drv_write | output | 1 | Write (record) level |
| drv_clk | output | 1 | Comms clock level |
| drv_dout | output | 1 | Comms data level |
| ser_dtr | input | 1 | DTR asserted |
| ser_txd | input | 1 | Serial transmit data line |
| ser_rxd | output | 1 | Serial receive data line |
| ser_rx_stb | output | 1 | ser_rxd updated |
| ser_cts | output | 1 | CTS asserted |
| ser_cts_stb | output | 1 | CTS changed |
| net_in | input | 1 | Network line input |
| net_busy | input | 1 | Network busy |
| net_out | output | 1 | Network line output |
| net_out_stb | output | 1 | net_out updated |
| net_wait_req | output | 1 | Network wait request |

## Verification
The assertions assume that cpu_rd and cpu_wr are never high in the same cycle. They also assume that no new strobe arrives while cpu_wait is high, as a stalled processor cannot issue one. The bench drives every access as a single-cycle strobe from a task that waits for its completion, so accesses never overlap. During a stall it releases the strobe and only moves drv_byte_rdy. Drive, serial and network inputs change only on falling edges, between accesses.

// File: rtl/exp_io_pkg.sv
package exp_io_pkg;

    localparam int BYTE_W     = 8;
    localparam int SEL_HI_BIT = 4;
    localparam int SEL_LO_BIT = 3;
    localparam int DRV_GRP_W  = 4;

    typedef enum logic [1:0] {
        PSEL_DATA   = 2'b00,
        PSEL_CTRL   = 2'b01,
        PSEL_SERNET = 2'b10,
        PSEL_NONE   = 2'b11
    } psel_e;

    // control byte bit positions (stored active-low)
    localparam int C_DOUT  = 0;
    localparam int C_CLK   = 1;
    localparam int C_RW    = 2;
    localparam int C_ERASE = 3;
    localparam int C_CTS   = 4;
    localparam int C_WAIT  = 5;

    // status byte bit positions (active-low)
    localparam int S_WPROT = 0;
    localparam int S_SYNC  = 1;
    localparam int S_GAP   = 2;
    localparam int S_DTR   = 3;
    localparam int S_BUSY  = 4;

    // serial/network byte bit positions
    localparam int N_NET = 0;
    localparam int N_TXD = BYTE_W - 1;

    localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hEE;
    localparam logic [BYTE_W-1:0] SERNET_RST = 8'h7E;
    localparam logic [BYTE_W-1:0] STAT_FILL  = 8'hE0;

endpackage

// File: rtl/exp_io_addr_dec.sv
module exp_io_addr_dec
    import exp_io_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              stall,
    output psel_e             psel,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic              pass_en
);
    always_comb begin
        psel    = psel_e'({addr[SEL_HI_BIT], addr[SEL_LO_BIT]});
        rd_hit  = rd && !stall && (psel != PSEL_NONE);
        wr_hit  = wr && !stall && (psel != PSEL_NONE);
        pass_en = (rd || wr) && (psel == PSEL_NONE);
    end
endmodule

// File: rtl/exp_io_ctrl_reg.sv
module exp_io_ctrl_reg
    import exp_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctrl,
    output logic              drv_stb,
    output logic              cts_stb,
    output logic              wait_req
);
    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic              drv_stb;
        logic              cts_stb;
        logic              wait_req;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.drv_stb  = 1'b0;
        st_d.cts_stb  = 1'b0;
        st_d.wait_req = 1'b0;
        if (wr_ctrl) begin
            st_d.ctrl     = wdata;
            st_d.drv_stb  = (wdata[DRV_GRP_W-1:0] != st_q.ctrl[DRV_GRP_W-1:0]);
            st_d.cts_stb  = (wdata[C_CTS] != st_q.ctrl[C_CTS]);
            st_d.wait_req = !wdata[C_WAIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl     <= CTRL_RST;
            st_q.drv_stb  <= 1'b0;
            st_q.cts_stb  <= 1'b0;
            st_q.wait_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign drv_stb  = st_q.drv_stb;
    assign cts_stb  = st_q.cts_stb;
    assign wait_req = st_q.wait_req;
endmodule

// File: rtl/exp_io_sernet.sv
module exp_io_sernet
    import exp_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sn,
    input  logic              rd_sn,
    input  logic              wbit,
    input  logic              route_ser,
    input  logic              net_refresh,
    input  logic              ser_txd,
    input  logic              net_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ser_rxd,
    output logic              ser_rx_stb,
    output logic              net_out,
    output logic              net_out_stb
);
    typedef struct packed {
        logic [BYTE_W-1:0] rbyte;
        logic              rxd;
        logic              rx_stb;
        logic              nout;
        logic              nout_stb;
    } sn_st_t;

    sn_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_stb   = 1'b0;
        st_d.nout_stb = 1'b0;
        if (wr_sn) begin
            if (route_ser) begin
                st_d.rxd    = !wbit;
                st_d.rx_stb = 1'b1;
            end else begin
                st_d.nout     = wbit;
                st_d.nout_stb = 1'b1;
            end
        end
        if (rd_sn) begin
            st_d.rbyte[N_TXD] = !ser_txd;
            if (net_refresh) begin
                st_d.rbyte[N_NET] = !net_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rbyte    <= SERNET_RST;
            st_q.rxd      <= 1'b0;
            st_q.rx_stb   <= 1'b0;
            st_q.nout     <= 1'b0;
            st_q.nout_stb <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_byte     = st_q.rbyte;
    assign ser_rxd     = st_q.rxd;
    assign ser_rx_stb  = st_q.rx_stb;
    assign net_out     = st_q.nout;
    assign net_out_stb = st_q.nout_stb;
endmodule

// File: rtl/exp_io_data_stall.sv
module exp_io_data_stall
    import exp_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_data,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              byte_rdy,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              stall,
    output logic              done,
    output logic              ack,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_stb
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic [BYTE_W-1:0] rbyte;
        logic [BYTE_W-1:0] tbyte;
        logic              tstb;
    } ds_st_t;

    ds_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.tstb = 1'b0;
        if (st_q.busy) begin
            if (byte_rdy) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.rbyte = rx_byte;
            end
        end else if (rd_data) begin
            if (byte_rdy) begin
                st_d.done  = 1'b1;
                st_d.rbyte = rx_byte;
            end else begin
                st_d.busy = 1'b1;
            end
        end
        if (wr_data) begin
            st_d.tbyte = wdata;
            st_d.tstb  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.done  <= 1'b0;
            st_q.rbyte <= '0;
            st_q.tbyte <= '0;
            st_q.tstb  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall   = st_q.busy;
    assign done    = st_q.done;
    assign ack     = st_q.done;
    assign rd_byte = st_q.rbyte;
    assign tx_byte = st_q.tbyte;
    assign tx_stb  = st_q.tstb;
endmodule

// File: rtl/exp_io_decoder.sv
module exp_io_decoder
    import exp_io_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rvalid,
    output logic              cpu_wait,
    output logic              pass_en,
    input  logic              drv_wprot,
    input  logic              drv_sync,
    input  logic              drv_gap,
    input  logic              drv_byte_rdy,
    input  logic [7:0]        drv_rx_byte,
    output logic              drv_rd_ack,
    output logic [7:0]        drv_tx_byte,
    output logic              drv_tx_stb,
    output logic              drv_ctrl_stb,
    output logic              drv_erase,
    output logic              drv_write,
    output logic              drv_clk,
    output logic              drv_dout,
    input  logic              ser_dtr,
    input  logic              ser_txd,
    output logic              ser_rxd,
    output logic              ser_rx_stb,
    output logic              ser_cts,
    output logic              ser_cts_stb,
    input  logic              net_in,
    input  logic              net_busy,
    output logic              net_out,
    output logic              net_out_stb,
    output logic              net_wait_req
);
    psel_e             psel;
    logic              rd_hit, wr_hit, stall;
    logic [BYTE_W-1:0] ctrl, sn_byte, dat_byte;
    logic              dat_done;

    exp_io_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (cpu_addr),
        .rd      (cpu_rd),
        .wr      (cpu_wr),
        .stall   (stall),
        .psel    (psel),
        .rd_hit  (rd_hit),
        .wr_hit  (wr_hit),
        .pass_en (pass_en)
    );

    exp_io_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_hit && psel == PSEL_CTRL),
        .wdata    (cpu_wdata),
        .ctrl     (ctrl),
        .drv_stb  (drv_ctrl_stb),
        .cts_stb  (ser_cts_stb),
        .wait_req (net_wait_req)
    );

    exp_io_sernet u_sn (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sn       (wr_hit && psel == PSEL_SERNET),
        .rd_sn       (rd_hit && psel == PSEL_SERNET),
        .wbit        (cpu_wdata[N_NET]),
        .route_ser   (ctrl[C_DOUT]),
        .net_refresh (ctrl[C_CTS]),
        .ser_txd     (ser_txd),
        .net_in      (net_in),
        .rd_byte     (sn_byte),
        .ser_rxd     (ser_rxd),
        .ser_rx_stb  (ser_rx_stb),
        .net_out     (net_out),
        .net_out_stb (net_out_stb)
    );

    exp_io_data_stall u_dat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_data  (rd_hit && psel == PSEL_DATA),
        .wr_data  (wr_hit && psel == PSEL_DATA),
        .wdata    (cpu_wdata),
        .byte_rdy (drv_byte_rdy),
        .rx_byte  (drv_rx_byte),
        .stall    (stall),
        .done     (dat_done),
        .ack      (drv_rd_ack),
        .rd_byte  (dat_byte),
        .tx_byte  (drv_tx_byte),
        .tx_stb   (drv_tx_stb)
    );

    typedef struct packed {
        logic              dtr;
        logic [BYTE_W-1:0] stat;
        psel_e             src;
        logic              rvalid;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.dtr    = ser_dtr;
        st_d.rvalid = 1'b0;
        if (rd_hit) begin
            st_d.src = psel;
            if (psel != PSEL_DATA) begin
                st_d.rvalid = 1'b1;
            end
            if (psel == PSEL_CTRL) begin
                st_d.stat          = STAT_FILL;
                st_d.stat[S_WPROT] = !drv_wprot;
                st_d.stat[S_SYNC]  = !drv_sync;
                st_d.stat[S_GAP]   = !drv_gap;
                st_d.stat[S_DTR]   = !st_q.dtr;
                st_d.stat[S_BUSY]  = !net_busy;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dtr    <= 1'b1;
            st_q.stat   <= STAT_FILL;
            st_q.src    <= PSEL_NONE;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cpu_rvalid = st_q.rvalid || dat_done;
        cpu_rdata  = '0;
        if (cpu_rvalid) begin
            case (st_q.src)
                PSEL_CTRL:   cpu_rdata = st_q.stat;
                PSEL_SERNET: cpu_rdata = sn_byte;
                PSEL_DATA:   cpu_rdata = dat_byte;
                default:     cpu_rdata = '0;
            endcase
        end
    end

    assign cpu_wait  = stall;
    assign drv_dout  = !ctrl[C_DOUT];
    assign drv_clk   = !ctrl[C_CLK];
    assign drv_write = !ctrl[C_RW];
    assign drv_erase = !ctrl[C_ERASE];
    assign ser_cts   = !ctrl[C_CTS];
endmodule

// File: rtl/exp_io_decoder_chk.sv
module exp_io_decoder_chk
    import exp_io_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic [7:0]        cpu_rdata,
    input logic              cpu_rvalid,
    input logic              cpu_wait,
    input logic              pass_en,
    input logic              drv_byte_rdy,
    input logic              drv_rd_ack,
    input logic              drv_ctrl_stb,
    input logic              drv_erase,
    input logic              drv_write,
    input logic              drv_clk,
    input logic              drv_dout,
    input logic              ser_cts,
    input logic              ser_cts_stb,
    input logic              ser_rx_stb,
    input logic              net_out_stb
);
    logic stat_rd;
    assign stat_rd = cpu_rd && !cpu_wait && !cpu_addr[SEL_HI_BIT] && cpu_addr[SEL_LO_BIT];

    AST_PASS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en && !cpu_wait |=> !cpu_rvalid); // R1
    AST_STATUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> cpu_rvalid && cpu_rdata[7:5] == 3'b111); // R3
    AST_DRV_STB_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_ctrl_stb |-> {drv_erase, drv_write, drv_clk, drv_dout}
                         != $past({drv_erase, drv_write, drv_clk, drv_dout})); // R6
    AST_DRV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_ctrl_stb |-> $stable({drv_erase, drv_write, drv_clk, drv_dout})); // R6
    AST_CTS_STB_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cts_stb |-> ser_cts != $past(ser_cts)); // R7
    AST_CTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cts_stb |-> $stable(ser_cts)); // R7
    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_rx_stb && net_out_stb)); // R9
    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_wait) |-> !$past(drv_byte_rdy)); // R11
    AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_wait) |-> cpu_rvalid && drv_rd_ack); // R11
endmodule

bind exp_io_decoder exp_io_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rd       (cpu_rd),
    .cpu_rdata    (cpu_rdata),
    .cpu_rvalid   (cpu_rvalid),
    .cpu_wait     (cpu_wait),
    .pass_en      (pass_en),
    .drv_byte_rdy (drv_byte_rdy),
    .drv_rd_ack   (drv_rd_ack),
    .drv_ctrl_stb (drv_ctrl_stb),
    .drv_erase    (drv_erase),
    .drv_write    (drv_write),
    .drv_clk      (drv_clk),
    .drv_dout     (drv_dout),
    .ser_cts      (ser_cts),
    .ser_cts_stb  (ser_cts_stb),
    .ser_rx_stb   (ser_rx_stb),
    .net_out_stb  (net_out_stb)
);

// File: tb/exp_io_decoder_test.sv
module exp_io_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_SN   = 16'h00F7;
    localparam logic [15:0] A_CTRL = 16'h00EF;
    localparam logic [15:0] A_DATA = 16'h00E7;
    localparam logic [15:0] A_FREE = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid, cpu_wait, pass_en;
    logic        drv_wprot = 1'b0, drv_sync = 1'b0, drv_gap = 1'b0, drv_byte_rdy = 1'b0;
    logic [7:0]  drv_rx_byte = '0;
    logic        drv_rd_ack;
    logic [7:0]  drv_tx_byte;
    logic        drv_tx_stb, drv_ctrl_stb, drv_erase, drv_write, drv_clk, drv_dout;
    logic        ser_dtr = 1'b1, ser_txd = 1'b1;
    logic        ser_rxd, ser_rx_stb, ser_cts, ser_cts_stb;
    logic        net_in = 1'b0, net_busy = 1'b1;
    logic        net_out, net_out_stb, net_wait_req;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_io_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .cpu_wait(cpu_wait), .pass_en(pass_en), .drv_wprot(drv_wprot), .drv_sync(drv_sync),
        .drv_gap(drv_gap), .drv_byte_rdy(drv_byte_rdy), .drv_rx_byte(drv_rx_byte),
        .drv_rd_ack(drv_rd_ack), .drv_tx_byte(drv_tx_byte), .drv_tx_stb(drv_tx_stb),
        .drv_ctrl_stb(drv_ctrl_stb), .drv_erase(drv_erase), .drv_write(drv_write),
        .drv_clk(drv_clk), .drv_dout(drv_dout), .ser_dtr(ser_dtr), .ser_txd(ser_txd),
        .ser_rxd(ser_rxd), .ser_rx_stb(ser_rx_stb), .ser_cts(ser_cts),
        .ser_cts_stb(ser_cts_stb), .net_in(net_in), .net_busy(net_busy),
        .net_out(net_out), .net_out_stb(net_out_stb), .net_wait_req(net_wait_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // write strobe; returns after the edge, outputs sampled on the falling edge
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    function automatic logic [7:0] levels();
        return {3'b000, ser_cts, drv_erase, drv_write, drv_clk, drv_dout};
    endfunction

    task automatic t_reset();
        check("R2 levels after reset", levels(), 8'h11);
        do_read(A_CTRL);
        check("R3 idle status rvalid", {7'b0, cpu_rvalid}, 8'h01);
        check("R2 idle status E7", cpu_rdata, 8'hE7);
        do_read(A_SN);
        check("R2 sernet reset 7E", cpu_rdata, 8'h7E);
    endtask

    task automatic t_status();
        drv_wprot = 1'b1; drv_gap = 1'b1;
        do_read(A_CTRL);
        check("R3 wprot+gap", cpu_rdata, 8'hE2);
        drv_wprot = 1'b0; drv_gap = 1'b0; drv_sync = 1'b1; net_busy = 1'b0;
        do_read(A_CTRL);
        check("R3 sync, busy clear", cpu_rdata, 8'hF5);
        drv_sync = 1'b0; net_busy = 1'b1; ser_dtr = 1'b0;
        @(negedge clk); @(negedge clk);
        do_read(A_CTRL);
        check("R4 dtr deasserted", cpu_rdata, 8'hEF);
        ser_dtr = 1'b1;
        @(negedge clk); @(negedge clk);
        do_read(A_CTRL);
        check("R4 dtr reasserted", cpu_rdata, 8'hE7);
    endtask

    task automatic t_ctrl();
        do_write(A_CTRL, 8'hEE);
        check("R6 R7 R8 no-change write strobes",
              {5'b0, drv_ctrl_stb, ser_cts_stb, net_wait_req}, 8'h00);
        do_write(A_CTRL, 8'hEF);
        check("R6 strobe on bit0 change", {6'b0, drv_ctrl_stb, ser_cts_stb}, 8'h02);
        check("R5 dout level", levels(), 8'h10);
        do_write(A_CTRL, 8'hFF);
        check("R7 cts strobe only", {6'b0, drv_ctrl_stb, ser_cts_stb}, 8'h01);
        check("R5 cts level", levels(), 8'h00);
        do_write(A_CTRL, 8'hDF);
        check("R8 wait req", {5'b0, drv_ctrl_stb, ser_cts_stb, net_wait_req}, 8'h01);
        do_write(A_CTRL, 8'hDF);
        check("R8 wait req repeat", {5'b0, drv_ctrl_stb, ser_cts_stb, net_wait_req}, 8'h01);
        do_write(A_CTRL, 8'hD0);
        check("R6 group change", {6'b0, drv_ctrl_stb, ser_cts_stb}, 8'h02);
        check("R5 all drive levels", levels(), 8'h0F);
    endtask

    task automatic t_route();
        do_write(A_CTRL, 8'hF1);           // bit0=1 serial, bit4=1 cts inactive
        do_write(A_SN, 8'h01);
        check("R9 serial strobe", {6'b0, ser_rx_stb, net_out_stb}, 8'h02);
        check("R9 rxd inverted of 1", {7'b0, ser_rxd}, 8'h00);
        do_write(A_SN, 8'h00);
        check("R9 rxd inverted of 0", {7'b0, ser_rxd}, 8'h01);
        do_write(A_CTRL, 8'hF0);           // bit0=0 network
        do_write(A_SN, 8'h01);
        check("R9 net strobe", {6'b0, ser_rx_stb, net_out_stb}, 8'h01);
        check("R9 net_out", {7'b0, net_out}, 8'h01);
    endtask

    task automatic t_sn_read();
        // ctrl bit4 = 1 from t_route: refresh enabled
        net_in = 1'b0; ser_txd = 1'b0;
        do_read(A_SN);
        check("R10 refresh net, txd", cpu_rdata, 8'hFF);
        do_write(A_CTRL, 8'hE0);           // bit4=0: cts active, hold latch
        net_in = 1'b1; ser_txd = 1'b1;
        do_read(A_SN);
        check("R10 net held while cts active", cpu_rdata, 8'h7F);
        do_write(A_CTRL, 8'hF0);
        do_read(A_SN);
        check("R10 net refreshed again", cpu_rdata, 8'h7E);
    endtask

    task automatic t_data();
        bit stayed;
        do_read(A_DATA);
        check("R11 wait raised", {6'b0, cpu_wait, cpu_rvalid}, 8'h02);
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cpu_wait || cpu_rvalid) stayed = 1'b0;
        end
        check("R11 stall held without byte", {7'b0, stayed}, 8'h01);
        drv_rx_byte = 8'hA5; drv_byte_rdy = 1'b1;
        @(negedge clk);
        drv_byte_rdy = 1'b0;
        check("R11 release flags", {5'b0, cpu_wait, cpu_rvalid, drv_rd_ack}, 8'h03);
        check("R11 byte", cpu_rdata, 8'hA5);
        drv_rx_byte = 8'h3C; drv_byte_rdy = 1'b1;
        do_read(A_DATA);
        drv_byte_rdy = 1'b0;
        check("R11 immediate flags", {6'b0, cpu_wait, cpu_rvalid}, 8'h01);
        check("R11 immediate byte", cpu_rdata, 8'h3C);
        do_write(A_DATA, 8'h5A);
        check("R12 tx strobe", {7'b0, drv_tx_stb}, 8'h01);
        check("R12 tx byte", drv_tx_byte, 8'h5A);
    endtask

    task automatic t_free();
        logic [7:0] lv;
        lv = levels();
        @(negedge clk);
        cpu_addr = A_FREE; cpu_rd = 1'b1;
        #1;
        check("R1 pass_en on read", {7'b0, pass_en}, 8'h01);
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R1 no rvalid", {7'b0, cpu_rvalid}, 8'h00);
        check("R1 rdata zero", cpu_rdata, 8'h00);
        do_write(A_FREE, 8'h00);
        check("R1 no strobes", {2'b0, drv_ctrl_stb, ser_cts_stb, net_wait_req,
              drv_tx_stb, ser_rx_stb, net_out_stb}, 8'h00);
        check("R1 levels untouched", levels(), lv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_ctrl();
        t_route();
        t_sn_read();
        t_data();
        t_free();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule